// File: doc/BRIEF.md
# Nibble Substitution Seed Mixer

This block turns one raw random byte into a mixed seed byte for a downstream bit-inversion encoder. An accepted byte is held in a register. Its two nibbles each go through a fixed 4-bit substitution table, and the two substituted values are summed to give the low nibble of the result. The high nibble of the result is the complement of the held byte's upper nibble.

A producer presents a byte together with a qualifier. Exactly one cycle later the mixed byte appears with its own qualifier. While the qualifier is low the output byte reads zero, so a consumer can sample the data lines without masking them. The random source that feeds the block is outside it.

Top module: `seed_mixer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears its state. After that edge `seed_byte` is 0x00 and `seed_valid` is 0.
- R2: `seed_valid` equals the value `in_valid` had at the previous rising edge, for every cycle after reset.
- R3: When `seed_valid` is 1, `seed_byte[7:4]` is the bitwise complement of bits [7:4] of the byte that was accepted at the previous edge.
- R4: When `seed_valid` is 1, `seed_byte[3:0]` is T(hi) + T(lo) modulo 16. Here hi and lo are bits [7:4] and [3:0] of the accepted byte, and T maps inputs 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2.
- R5: A nibble sum of 16 or more drops its carry. For example, input 0x0A gives T(0)+T(A) = 0x1B, so the low nibble is 0xB and the result is 0xFB.
- R6: When `seed_valid` is 0, `seed_byte` is 0x00.
- R7: Valid bytes offered on consecutive cycles produce one result each, on consecutive cycles, in the same order.
- R8: A byte on `in_byte` while `in_valid` is 0 is not stored. In the next cycle the output is 0x00 with `seed_valid` 0, and the next valid byte's result does not depend on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_byte | input | 8 | Raw random byte |
| in_valid | input | 1 | Qualifies `in_byte` in this cycle |
| seed_byte | output | 8 | Mixed seed byte; zero when not valid |
| seed_valid | output | 1 | Qualifies `seed_byte` |

## Verification
The clocked properties treat `in_valid` and `in_byte` as known (not X or Z) at every rising edge once reset is released. The property on the inverted high nibble looks one cycle back at the input, so it depends on `in_byte` being held steady around each edge. The bench drives every input on the falling edge only and leaves it unchanged across the rising edge, which keeps all values defined. Reset is held low from time zero through several edges before any stimulus starts.

// File: rtl/seed_mixer_pkg.sv
// Package: shared widths and the fixed 4-bit substitution table.
// Assumes the byte is exactly two nibbles wide.
package seed_mixer_pkg;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Fixed nonlinear substitution of one nibble.
    function automatic nib_t subst_nib(input nib_t x);
        case (x)
            4'h0: subst_nib = 4'hC;
            4'h1: subst_nib = 4'h5;
            4'h2: subst_nib = 4'h6;
            4'h3: subst_nib = 4'hB;
            4'h4: subst_nib = 4'h9;
            4'h5: subst_nib = 4'h0;
            4'h6: subst_nib = 4'hA;
            4'h7: subst_nib = 4'hD;
            4'h8: subst_nib = 4'h3;
            4'h9: subst_nib = 4'hE;
            4'hA: subst_nib = 4'hF;
            4'hB: subst_nib = 4'h8;
            4'hC: subst_nib = 4'h4;
            4'hD: subst_nib = 4'h7;
            4'hE: subst_nib = 4'h1;
            default: subst_nib = 4'h2;
        endcase
    endfunction
endpackage

// File: rtl/nib_sbox.sv
// nib_sbox: combinational 4-bit substitution lane.
// Assumes: none; purely combinational.
module nib_sbox
    import seed_mixer_pkg::*;
(
    input  nib_t nib_in,
    output nib_t nib_out
);
    // Table lookup for one nibble.
    always_comb nib_out = subst_nib(nib_in);
endmodule

// File: rtl/seed_capture.sv
// seed_capture: holds the accepted raw byte and the one-cycle valid flag.
// Assumes: in_valid is a single-cycle qualifier; synchronous active-low reset.
module seed_capture
    import seed_mixer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  byte_t din,
    input  logic  din_vld,
    output byte_t held,
    output logic  held_vld
);
    // Load the byte only when qualified; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       held <= '0;
        else if (din_vld) held <= din;
    end

    // Delay the qualifier by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) held_vld <= 1'b0;
        else        held_vld <= din_vld;
    end

    // R8: an unqualified byte leaves the stored byte untouched.
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !din_vld |=> $stable(held));
endmodule

// File: rtl/nibble_mix.sv
// nibble_mix: substitutes both nibbles, sums them mod 16 into the low nibble,
// places the complemented upper nibble on top, and zeroes the byte when idle.
// Assumes: held is meaningful only while vld is high.
module nibble_mix
    import seed_mixer_pkg::*;
(
    input  byte_t held,
    input  logic  vld,
    output byte_t mixed
);
    localparam int LANES = BYTE_W / NIB_W;

    nib_t lane_in  [LANES];
    nib_t lane_out [LANES];
    nib_t sum_nib;
    nib_t top_nib;

    // One substitution lane per nibble.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_in[g] = held[g*NIB_W +: NIB_W];
        nib_sbox u_sbox (.nib_in(lane_in[g]), .nib_out(lane_out[g]));
    end

    // Modulo-16 sum of the substituted nibbles; carry falls off the width.
    always_comb sum_nib = lane_out[1] + lane_out[0];

    // Complement of the upper raw nibble.
    always_comb top_nib = ~held[BYTE_W-1 -: NIB_W];

    // Assemble and gate the result with valid.
    always_comb mixed = vld ? {top_nib, sum_nib} : '0;
endmodule

// File: rtl/seed_mixer.sv
// seed_mixer: top level; one-cycle registered nibble mixer for seed bytes.
// Assumes: synchronous active-low reset; inputs stable around the rising edge.
module seed_mixer
    import seed_mixer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_byte,
    input  logic       in_valid,
    output logic [7:0] seed_byte,
    output logic       seed_valid
);
    byte_t held;
    logic  held_vld;

    seed_capture u_cap (
        .clk(clk), .rst_n(rst_n), .din(in_byte), .din_vld(in_valid),
        .held(held), .held_vld(held_vld)
    );

    nibble_mix u_mix (.held(held), .vld(held_vld), .mixed(seed_byte));

    assign seed_valid = held_vld;

    // R2: qualifier follows input with one cycle of latency.
    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> seed_valid);
    assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !seed_valid);
    // R3: upper output nibble is the complement of the accepted upper nibble.
    assert_top_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> seed_byte[7:4] == ~$past(in_byte[7:4]));
    // R6: idle output byte is zero.
    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !seed_valid |-> seed_byte == 8'h00);
endmodule

// File: tb/tb_seed_mixer.sv
module tb_seed_mixer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_valid = 1'b0;
    logic [7:0] seed_byte;
    logic       seed_valid;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    seed_mixer dut (.*);

    always #2 clk = ~clk;

    function automatic logic [3:0] tsub(input logic [3:0] x);
        logic [3:0] t [16] = '{4'hC,4'h5,4'h6,4'hB,4'h9,4'h0,4'hA,4'hD,
                               4'h3,4'hE,4'hF,4'h8,4'h4,4'h7,4'h1,4'h2};
        return t[x];
    endfunction

    function automatic logic [7:0] model(input logic [7:0] d);
        logic [3:0] s = tsub(d[7:4]) + tsub(d[3:0]);
        return {~d[7:4], s};
    endfunction

    task automatic check(input string req, input logic [7:0] act_b, input logic act_v,
                         input logic [7:0] exp_b, input logic exp_v);
        n_run++;
        if (act_b !== exp_b || act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: byte=%02h valid=%0b expected byte=%02h valid=%0b",
                     req, act_b, act_v, exp_b, exp_v);
        end
    endtask

    // Present one byte for one cycle, then sample after the capturing edge.
    task automatic send_check(input string req, input logic [7:0] d);
        @(negedge clk); in_byte = d; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        check(req, seed_byte, seed_valid, model(d), 1'b1);
    endtask

    task automatic t_reset;  // R1
        check("R1", seed_byte, seed_valid, 8'h00, 1'b0);
    endtask

    task automatic t_basic;  // R3, R4
        send_check("R4", 8'h00);
        send_check("R4", 8'hFF);
        send_check("R3", 8'h12);
        send_check("R3", 8'hD0);
        check("R4 known", model(8'h12), 1'b1, 8'hEB, 1'b1);
    endtask

    task automatic t_carry;  // R5
        send_check("R5", 8'h0A);
        check("R5 known", model(8'h0A), 1'b1, 8'hFB, 1'b1);
    endtask

    task automatic t_idle;  // R6, R2
        @(negedge clk); in_valid = 1'b0; in_byte = 8'h5A;
        @(negedge clk);
        check("R6", seed_byte, seed_valid, 8'h00, 1'b0);
        check("R2", 8'h00, seed_valid, 8'h00, 1'b0);
    endtask

    task automatic t_stream;  // R7
        logic [7:0] seq [4] = '{8'h3C, 8'hA5, 8'h81, 8'h7E};
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            in_byte = seq[i]; in_valid = 1'b1;
            @(negedge clk);
            check("R7", seed_byte, seed_valid, model(seq[i]), 1'b1);
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R2", seed_byte, seed_valid, 8'h00, 1'b0);
    endtask

    task automatic t_ignore;  // R8
        send_check("R8", 8'h44);
        @(negedge clk); in_byte = 8'hB7; in_valid = 1'b0;
        @(negedge clk);
        check("R8", seed_byte, seed_valid, 8'h00, 1'b0);
        in_byte = 8'h09; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        check("R8", seed_byte, seed_valid, model(8'h09), 1'b1);
    endtask

    task automatic t_rereset;  // R1 mid-run
        @(negedge clk); in_byte = 8'h66; in_valid = 1'b1; rst_n = 1'b0;
        @(negedge clk); in_valid = 1'b0;
        check("R1", seed_byte, seed_valid, 8'h00, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_carry();
        t_idle();
        t_stream();
        t_ignore();
        t_rereset();
        for (int v = 0; v < 256; v += 17) send_check("R4", 8'(v));
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: byte=%02h valid=%0b expected completion",
                         seed_byte, seed_valid);
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule